// File: doc/BRIEF.md
# Hot-Plug Expander Link Manager

This block keeps the hot-plug signals of two downstream ports in step with an external I/O expander that sits on the management SMBus. The port logic presents its hot-plug output values as one packed image. Whenever that image changes, the block asks a byte-level SMBus master to write the complete image to the expander. The expander reports a change on its hot-plug inputs by pulling an active-low interrupt line, which reaches the block through a general-purpose pin. The block answers each interrupt by reading the whole input image, storing it, and pulsing a per-bit mask of the inputs that changed.

Nothing starts until the configuration-done input is high, so reset and configuration loading finish before any bus traffic. Writes and reads run one at a time. A pending write is served before a read. A NACK from the expander sets a sticky error bit, and the same transaction is sent once more. If that second attempt is also refused, the transaction is dropped. The bus speed strap is captured while reset is asserted and is passed to the master unchanged from then on.

The sequencer has four states: IDLE, WRITE, READ and APPLY. Its transitions are:
- IDLE to WRITE: enabled and a write is pending.
- IDLE to READ: enabled, no write pending, and the synchronized interrupt is low.
- WRITE to IDLE: the final acknowledge arrives, either a success or a second NACK.
- READ to APPLY: the final acknowledge arrives.
- APPLY to IDLE: always, after one cycle.
- WRITE and READ stay in place on a first NACK, which is the retry.

Top module: `hpx_mgr`

## Requirements
- R1: While `cfg_done_i` is low the block raises no request; output changes seen in that time stay pending and are written once it goes high.
- R2: Any change of `hp_out_i` causes one write request (`mst_rd_o`=0) with `mst_addr_o` equal to the expander address and `mst_wdata_o` equal to the full output image (port p occupies bits [p*PER_PORT +: PER_PORT]).
- R3: A change of `hp_out_i` during a write in progress leads to one further write carrying the newer image.
- R4: With no write pending, the enabled block raises a read request (`mst_rd_o`=1) when `exp_int_n_i` is low.
- R5: After a successful read, `hp_in_o` takes the read data. For exactly one cycle, `hp_chg_o` then equals the old image XOR the new image, with 1 marking a bit that changed. Otherwise `hp_chg_o` is zero.
- R6: If the interrupt is still low when a read completes, another read is issued.
- R7: When a write and a read are both pending, the write goes first.
- R8: On a NACK, `nack_err_o` is set and stays set until reset, and the identical transaction is repeated once. A second NACK drops it and pulses `drop_o` for one cycle. A dropped read leaves `hp_in_o` unchanged.
- R9: `bus_slow_o` (1 = 100 kHz, 0 = 400 kHz) takes the strap value during reset and keeps it until the next reset, whatever the strap does.
- R10: A request stays high with stable direction and data until the master pulses `mst_done_i`. After the final acknowledge of a transaction, it drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done_i | input | 1 | Reset and configuration loading finished |
| slow_strap_i | input | 1 | Bus speed strap, captured during reset |
| hp_out_i | input | IMG_W | Hot-plug output image from the port logic |
| exp_int_n_i | input | 1 | Expander interrupt, active low, asynchronous |
| mst_req_o | output | 1 | Transaction request to the byte master |
| mst_rd_o | output | 1 | 1 = read, 0 = write |
| mst_addr_o | output | 7 | Expander bus address |
| mst_wdata_o | output | IMG_W | Output image to write |
| mst_done_i | input | 1 | One-cycle acknowledge that the transaction ended |
| mst_nack_i | input | 1 | Valid with done: the expander refused |
| mst_rdata_i | input | IMG_W | Valid with done on a read: the input image |
| bus_slow_o | output | 1 | Captured speed selection to the master |
| hp_in_o | output | IMG_W | Last input image read |
| hp_chg_o | output | IMG_W | One-cycle mask of the input bits that changed |
| nack_err_o | output | 1 | Sticky NACK error |
| drop_o | output | 1 | One-cycle pulse when a transaction is dropped |

## Verification
The bench sweeps many output and input images and checks the contents and count of every transaction. It targets the orderings where a sequencer is easily wrong:
- An output change that lands in the middle of a write. A design that clears its pending flag on completion instead of at launch would lose the second write.
- An output change that lands in the middle of a read while the interrupt stays low. A design with the wrong priority would read twice before writing.
- A level interrupt held over several reads. A design treating the interrupt as an edge would stop after one read.
- Single and double NACKs. A design without the retry would issue one attempt too few. A design without the drop would loop forever or overwrite the input image with rejected data.
- Changing the strap after reset. This exposes a speed selection that is not latched.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
    typedef enum logic [1:0] {
        HPX_IDLE  = 2'd0,
        HPX_WRITE = 2'd1,
        HPX_READ  = 2'd2,
        HPX_APPLY = 2'd3
    } hpx_state_e;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b1;
                else        r <= d_i;
            end
            assign q_o = r;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '1;
                else        sr <= {sr[STAGES-2:0], d_i};
            end
            assign q_o = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hpx_out_track.sv
module hpx_out_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] img_i,
    input  logic         take_i,
    output logic         pend_o,
    output logic [W-1:0] snap_o
);
    logic [W-1:0] prev_q;
    logic         moved;

    assign moved = (img_i != prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= img_i;
            pend_o <= 1'b0;
            snap_o <= '0;
        end else begin
            prev_q <= img_i;
            if (take_i) snap_o <= img_i;
            // a launch captures the live image, so only later changes re-arm
            pend_o <= !take_i && (pend_o || moved);
        end
    end
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
    import hpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         wr_pend_i,
    input  logic         int_low_i,
    input  logic         mst_done_i,
    input  logic         mst_nack_i,
    input  logic [W-1:0] mst_rdata_i,
    output logic         take_o,
    output logic         mst_req_o,
    output logic         mst_rd_o,
    output logic         apply_o,
    output logic [W-1:0] rbuf_o,
    output logic         err_o,
    output logic         drop_o,
    output hpx_state_e   state_o
);
    hpx_state_e state_q, state_d;
    logic       retried_q;
    logic       rd_ok_q;
    logic       final_ack;

    assign final_ack = mst_done_i && (!mst_nack_i || retried_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HPX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HPX_IDLE: begin
                if (en_i && wr_pend_i)      state_d = HPX_WRITE;
                else if (en_i && int_low_i) state_d = HPX_READ;
            end
            HPX_WRITE: if (final_ack) state_d = HPX_IDLE;
            HPX_READ:  if (final_ack) state_d = HPX_APPLY;
            HPX_APPLY: state_d = HPX_IDLE;
            default:   state_d = HPX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take_o    = 1'b0;
        mst_req_o = 1'b0;
        mst_rd_o  = 1'b0;
        apply_o   = 1'b0;
        unique case (state_q)
            HPX_IDLE:  take_o = en_i && wr_pend_i;
            HPX_WRITE: mst_req_o = 1'b1;
            HPX_READ: begin
                mst_req_o = 1'b1;
                mst_rd_o  = 1'b1;
            end
            HPX_APPLY: apply_o = rd_ok_q;
            default: ;
        endcase
    end

    // retry, status and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retried_q <= 1'b0;
            rd_ok_q   <= 1'b0;
            rbuf_o    <= '0;
            err_o     <= 1'b0;
            drop_o    <= 1'b0;
        end else begin
            drop_o <= 1'b0;
            if (state_q == HPX_IDLE) retried_q <= 1'b0;
            if (mst_req_o && mst_done_i) begin
                if (mst_nack_i) begin
                    err_o <= 1'b1;
                    if (retried_q) drop_o    <= 1'b1;
                    else           retried_q <= 1'b1;
                end
                if (mst_rd_o) begin
                    rd_ok_q <= !mst_nack_i;
                    if (!mst_nack_i) rbuf_o <= mst_rdata_i;
                end
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/hpx_in_image.sv
module hpx_in_image #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         apply_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] img_o,
    output logic [W-1:0] chg_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_o <= '0;
            chg_o <= '0;
        end else if (apply_i) begin
            img_o <= data_i;
            chg_o <= img_o ^ data_i;
        end else begin
            chg_o <= '0;
        end
    end
endmodule

// File: rtl/hpx_mgr.sv
module hpx_mgr
    import hpx_pkg::*;
#(
    parameter int         NPORTS      = 2,
    parameter int         PER_PORT    = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    localparam int        IMG_W       = NPORTS * PER_PORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done_i,
    input  logic             slow_strap_i,
    input  logic [IMG_W-1:0] hp_out_i,
    input  logic             exp_int_n_i,
    output logic             mst_req_o,
    output logic             mst_rd_o,
    output logic [6:0]       mst_addr_o,
    output logic [IMG_W-1:0] mst_wdata_o,
    input  logic             mst_done_i,
    input  logic             mst_nack_i,
    input  logic [IMG_W-1:0] mst_rdata_i,
    output logic             bus_slow_o,
    output logic [IMG_W-1:0] hp_in_o,
    output logic [IMG_W-1:0] hp_chg_o,
    output logic             nack_err_o,
    output logic             drop_o
);
    logic             int_n_s;
    logic             int_low;
    logic             wr_pend;
    logic             take;
    logic             apply;
    logic [IMG_W-1:0] rbuf;
    hpx_state_e       state;

    always_ff @(posedge clk) begin
        if (!rst_n) bus_slow_o <= slow_strap_i;
    end

    hpx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (exp_int_n_i),
        .q_o   (int_n_s)
    );
    assign int_low = !int_n_s;

    hpx_out_track #(.W(IMG_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .img_i  (hp_out_i),
        .take_i (take),
        .pend_o (wr_pend),
        .snap_o (mst_wdata_o)
    );

    hpx_seq #(.W(IMG_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cfg_done_i),
        .wr_pend_i   (wr_pend),
        .int_low_i   (int_low),
        .mst_done_i  (mst_done_i),
        .mst_nack_i  (mst_nack_i),
        .mst_rdata_i (mst_rdata_i),
        .take_o      (take),
        .mst_req_o   (mst_req_o),
        .mst_rd_o    (mst_rd_o),
        .apply_o     (apply),
        .rbuf_o      (rbuf),
        .err_o       (nack_err_o),
        .drop_o      (drop_o),
        .state_o     (state)
    );

    hpx_in_image #(.W(IMG_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply_i (apply),
        .data_i  (rbuf),
        .img_o   (hp_in_o),
        .chg_o   (hp_chg_o)
    );

    assign mst_addr_o = DEV_ADDR;
endmodule

// File: rtl/hpx_mgr_chk.sv
module hpx_mgr_chk
    import hpx_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         wr_pend,
    input logic         int_low,
    input hpx_state_e   state,
    input logic         req,
    input logic         rd,
    input logic [W-1:0] wdata,
    input logic         done,
    input logic         nack,
    input logic         bus_slow,
    input logic [W-1:0] chg,
    input logic         err,
    input logic         drop
);
    AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && !req) |=> !req); // R1
    AST_CHG_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) (chg != '0) |-> $past(done && !nack && rd && req, 2)); // R5
    AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (chg != '0) |=> (chg == '0)); // R5
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (state == HPX_IDLE && en && wr_pend && int_low) |=> (req && !rd)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R8
    AST_DROP_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n) drop |-> $past(done && nack && req)); // R8
    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n) $stable(bus_slow)); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (req && !done) |=> (req && $stable(rd) && $stable(wdata))); // R10
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (req && done && !nack) |=> !req); // R10
endmodule

bind hpx_mgr hpx_mgr_chk #(.W(IMG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_done_i),
    .wr_pend  (wr_pend),
    .int_low  (int_low),
    .state    (state),
    .req      (mst_req_o),
    .rd       (mst_rd_o),
    .wdata    (mst_wdata_o),
    .done     (mst_done_i),
    .nack     (mst_nack_i),
    .bus_slow (bus_slow_o),
    .chg      (hp_chg_o),
    .err      (nack_err_o),
    .drop     (drop_o)
);

// File: tb/tb_hpx_mgr.sv
module tb_hpx_mgr;
    localparam int W   = 8;
    localparam int LAT = 4;
    localparam int WD  = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_done = 1'b0;
    logic         strap = 1'b1;
    logic [W-1:0] hp_out = '0;
    logic         exp_int_n;
    logic         req, rd, bus_slow, err, drop;
    logic [6:0]   addr;
    logic [W-1:0] wdata, hp_in, hp_chg;
    logic         done = 1'b0;
    logic         nack = 1'b0;
    logic [W-1:0] rdata = '0;

    always #5 clk = ~clk;

    hpx_mgr dut (
        .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done), .slow_strap_i(strap),
        .hp_out_i(hp_out), .exp_int_n_i(exp_int_n),
        .mst_req_o(req), .mst_rd_o(rd), .mst_addr_o(addr), .mst_wdata_o(wdata),
        .mst_done_i(done), .mst_nack_i(nack), .mst_rdata_i(rdata),
        .bus_slow_o(bus_slow), .hp_in_o(hp_in), .hp_chg_o(hp_chg),
        .nack_err_o(err), .drop_o(drop)
    );

    int n_chk = 0, n_fail = 0;
    int arm_seq = 0, rel_seq = 0, seen_arm = 0;
    int rel_after = 1, rd_att = 0, nack_left = 0;
    logic [W-1:0] exp_in = '0;
    int ntx = 0, wr_cnt = 0, rd_cnt = 0, hold_viol = 0, cnt = 0;
    logic         ops [0:255];
    logic [W-1:0] wds [0:255];
    logic         s_rd;
    logic [W-1:0] s_wd;
    int chg_cnt = 0, drop_cnt = 0;
    logic [W-1:0] last_chg = '0;

    assign exp_int_n = (arm_seq == rel_seq);

    // expander and byte master model
    always @(negedge clk) begin
        if (arm_seq != seen_arm) begin seen_arm = arm_seq; rd_att = 0; end
        if (done) begin
            done = 1'b0; nack = 1'b0; cnt = 0;
        end else if (req) begin
            if (cnt == 0) begin s_rd = rd; s_wd = wdata; end
            else if (rd != s_rd || (!rd && wdata != s_wd)) hold_viol++;
            cnt++;
            if (cnt == LAT) begin
                done = 1'b1;
                nack = (nack_left > 0);
                if (nack_left > 0) nack_left--;
                if (ntx < 256) begin ops[ntx] = rd; wds[ntx] = wdata; end
                ntx++;
                if (rd) begin
                    rd_cnt++; rd_att++;
                    rdata = exp_in;
                    if (rd_att >= rel_after) rel_seq = arm_seq;
                end else wr_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && hp_chg != '0) begin chg_cnt++; last_chg = hp_chg; end
        if (rst_n && drop) drop_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w0, r0, c0, t0, d0;
        logic [W-1:0] prev_in, v, a, b;
        prev_in = '0;
        idle(5);
        // reset state
        check("R9 reset strap", int'(bus_slow), 1);
        check("R10 reset req", int'(req), 0);
        check("R5 reset image", int'(hp_in), 0);
        check("R5 reset chg", int'(hp_chg), 0);
        check("R8 reset err", int'(err), 0);
        rst_n = 1'b1;
        idle(2);
        strap = 1'b0;
        idle(5);
        check("R9 strap ignored after reset", int'(bus_slow), 1);

        // R1: disabled block stays quiet, change is kept pending
        hp_out = 8'h5A;
        idle(20);
        check("R1 no write while off", wr_cnt, 0);
        check("R1 req low while off", int'(req), 0);
        cfg_done = 1'b1;
        idle(30);
        check("R1 pending write after enable", wr_cnt, 1);
        check("R2 full image", int'(wds[ntx-1]), 8'h5A);
        check("R2 address", int'(addr), 7'h20);

        // R2 sweep over output images
        for (int k = 0; k < 16; k++) begin
            v = W'((k * 37 + 11) & 8'hFF);
            w0 = wr_cnt;
            hp_out = v;
            idle(20);
            check("R2 one write per change", wr_cnt - w0, 1);
            check("R2 write data", int'(wds[ntx-1]), int'(v));
        end

        // R3: change during a write
        w0 = wr_cnt; a = 8'hC3; b = 8'h3C;
        hp_out = a;
        idle(4);
        hp_out = b;
        idle(40);
        check("R3 two writes", wr_cnt - w0, 2);
        check("R3 first image", int'(wds[ntx-2]), int'(a));
        check("R3 newest image", int'(wds[ntx-1]), int'(b));

        // R4/R5 sweep over input images
        for (int k = 0; k < 12; k++) begin
            v = W'((k * 53 + 7) & 8'hFF);
            r0 = rd_cnt; c0 = chg_cnt;
            exp_in = v; rel_after = 1; arm_seq++;
            idle(30);
            check("R4 one read per interrupt", rd_cnt - r0, 1);
            check("R5 image updated", int'(hp_in), int'(v));
            check("R5 one change pulse", chg_cnt - c0, 1);
            check("R5 change mask", int'(last_chg), int'(prev_in ^ v));
            prev_in = v;
        end

        // R6: interrupt held over three reads
        r0 = rd_cnt; c0 = chg_cnt;
        exp_in = 8'hA5; rel_after = 3; arm_seq++;
        idle(60);
        check("R6 reads while low", rd_cnt - r0, 3);
        check("R6 single change pulse", chg_cnt - c0, 1);
        prev_in = 8'hA5;

        // R7: output change during a read with interrupt still low
        t0 = ntx;
        exp_in = 8'h96; rel_after = 2; arm_seq++;
        do @(negedge clk); while (!(req && rd));
        hp_out = 8'h77;
        idle(60);
        check("R7 count", ntx - t0, 3);
        check("R7 first read", int'(ops[t0]), 1);
        check("R7 write next", int'(ops[t0+1]), 0);
        check("R7 read last", int'(ops[t0+2]), 1);
        check("R7 write data", int'(wds[t0+1]), 8'h77);
        prev_in = 8'h96;

        // R8: single NACK on a write
        check("R8 no error yet", int'(err), 0);
        w0 = wr_cnt; d0 = drop_cnt;
        nack_left = 1;
        hp_out = 8'h1E;
        idle(40);
        check("R8 write retried", wr_cnt - w0, 2);
        check("R8 retry same data", int'(wds[ntx-2]), int'(wds[ntx-1]));
        check("R8 error set", int'(err), 1);
        check("R8 no drop", drop_cnt - d0, 0);

        // R8: double NACK on a read
        r0 = rd_cnt; c0 = chg_cnt;
        nack_left = 2; exp_in = 8'hF0; rel_after = 2; arm_seq++;
        idle(50);
        check("R8 read attempts", rd_cnt - r0, 2);
        check("R8 drop pulse", drop_cnt - d0, 1);
        check("R8 image kept", int'(hp_in), int'(prev_in));
        check("R8 no change pulse", chg_cnt - c0, 0);
        check("R8 error still set", int'(err), 1);
        check("R9 strap still ignored", int'(bus_slow), 1);

        // R10: request held stable through every transaction
        check("R10 stable request", hold_viol, 0);
        check("R10 idle at end", int'(req), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule